// File: doc/BRIEF.md
# Instruction Word Decoder

This block classifies the first word of a 16-bit instruction stream and pulls out the fields a datapath needs. Instructions take one or two words. The decoder looks at the first word only. It reports the following:

- the instruction class;
- the arithmetic operation and its operand-addressing mode;
- the raw register and immediate fields;
- the jump condition and direction;
- multiply and accumulate details;
- call or goto;
- interrupt-control actions;
- multi-register stack transfers;
- whether a second word follows;
- whether the encoding is illegal.

The decoder does not fetch words, read registers or execute anything.

The classes share one opcode space, so the order of the checks matters. A primary opcode of 0xF always opens the special group. Otherwise, a destination field naming the program counter (register 7) turns the word into a relative jump. The stack transfers and the shift modes are carried in the secondary-opcode and parameter fields.

The decode is combinational. A single output register stage, with a synchronous active-low reset, sits in front of the ports. The decode of a word applied before a rising clock edge therefore appears at the outputs just after that edge.

Top module: `idec_word`

## Requirements
- R1: The outputs register the decode of `instr_i` one clock after it is applied. A clock edge taken with `rst_n` low clears every output to zero.
- R2: The word is split into the following fields: primary opcode [15:12], operand A [11:9], secondary opcode [8:6], parameter [5:3] and operand B [2:0], with a 6-bit immediate in [5:0]. A primary opcode of 0xF never yields class ALU (1), jump (2) or stack (7). The class codes are 0 none/illegal, 1 ALU, 2 jump, 3 multiply, 4 MAC, 5 call/goto, 6 interrupt control and 7 stack. `ra_o`, `rb_o` and `imm6_o` always carry the raw fields.
- R3: If operand A is 7 and the primary opcode is not 0xF, the word is a jump.
  - `jcond_o` is the primary opcode.
  - `jback_o` is bit 6.
  - A nonzero bit 8 or bit 7 makes the word illegal.
- R4: The ALU primary opcodes are 0, 1, 2, 3, 4, 6, 8, 9, 0xA, 0xB, 0xC and 0xD. For these, `alu_op_o` equals the opcode. Opcodes 5, 7 and 0xE with operand A other than 7 are illegal.
- R5: For an ALU word, the secondary opcode selects `amode_o` as follows:
  - secondary 0 gives 1 (base-pointer relative);
  - secondary 1 gives 2 (imm6);
  - secondary 3 gives 3 (register indirect);
  - secondary 7 gives 13 (6-bit absolute);
  - secondary 4 with parameter 0 gives 4 (register);
  - secondary 4 with parameters 1, 2 and 3 gives 5 (imm16), 6 (load from addr16) and 7 (store to addr16);
  - secondary 4 with a parameter of 4 to 7 gives 8 (arithmetic right shift);
  - secondary 5 gives 9 (left shift) or 10 (logical right shift);
  - secondary 6 gives 11 (rotate left) or 12 (rotate right).
  For the pairs under secondary 5 and secondary 6, parameter bit 2 set selects the second mode.
- R6: In indirect mode, `ind_ds_o` is parameter bit 2 and `ind_upd_o` is parameter bits 1:0. In every shift mode, `shamt_o` is parameter bits 1:0 plus 1, giving a range of 1 to 4.
- R7: `two_word_o` is 1 for ALU modes 5, 6 and 7, for call and for goto. It is 0 for every other word.
- R8: Secondary opcode 2 gives the stack class, with `stk_cnt_o` equal to the parameter.
  - With primary opcode 9 it is a pop, with `push_o` 0.
  - With primary opcode 0xD it is a push, with `push_o` 1.
  - With any other ALU opcode, secondary opcode 2 is illegal.
- R9: In the special group, the multiply class is decoded as follows:
  - Secondary 0 with parameter 1 is an unsigned-by-signed multiply, with `mul_signed_o` 0.
  - Secondary 4 with parameter 1 is a signed-by-signed multiply, with `mul_signed_o` 1.
  - Any other parameter is illegal.
  - Operand A or operand B equal to 0, 6 or 7 is illegal.
- R10: In the special group, the MAC class is decoded as follows:
  - Secondary 2 (with operand A not 7) and secondary 3 are unsigned-by-signed, with `mul_signed_o` 0.
  - Secondary 6 and secondary 7 are signed-by-signed, with `mul_signed_o` 1.
  - `mac_len_o` is 8 times bit 6 plus the parameter, and a result of 0 means 16.
  - Operands 0, 3, 4, 6 and 7 are illegal.
- R11: In the special group, secondary 1 is a call with `goto_o` 0. Secondary 2 with operand A equal to 7 is a goto with `goto_o` 1. Both belong to class 5.
- R12: In the special group, secondary 5 is interrupt control, and `imm6_o` selects `intc_o`:
  - 0x00 to 0x03 give 1 (set enables), with `int_en_o` equal to imm[1:0], where bit 0 is the normal interrupt and bit 1 the fast interrupt;
  - 0x04 gives 2 (coefficient-move on) and 0x05 gives 3 (coefficient-move off);
  - 0x08 gives 4 (normal interrupt off) and 0x09 gives 5 (normal interrupt on);
  - 0x0C gives 6 (fast interrupt off) and 0x0E gives 7 (fast interrupt on);
  - 0x20 gives 8 (break);
  - every other value is illegal.
- R13: For an illegal word, `illegal_o` is 1 and `cls_o` is 0. Every class-specific output is then 0, including `two_word_o`, `amode_o`, `intc_o` and `push_o`. `ra_o`, `rb_o` and `imm6_o` still carry the raw fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_i | input | 16 | First instruction word |
| cls_o | output | 3 | Instruction class code |
| illegal_o | output | 1 | Encoding not recognised |
| two_word_o | output | 1 | A second word follows |
| alu_op_o | output | 4 | ALU operation (primary opcode) |
| amode_o | output | 4 | ALU addressing mode code |
| shamt_o | output | 3 | Shift amount, 1 to 4 |
| ind_ds_o | output | 1 | Indirect access uses the data-segment prefix |
| ind_upd_o | output | 2 | Indirect pointer update kind |
| ra_o | output | 3 | Operand A field |
| rb_o | output | 3 | Operand B field |
| imm6_o | output | 6 | 6-bit immediate field |
| jcond_o | output | 4 | Jump condition code |
| jback_o | output | 1 | Jump offset is backward |
| mul_signed_o | output | 1 | First multiply operand is signed |
| mac_len_o | output | 5 | MAC length, 1 to 16 |
| goto_o | output | 1 | Call/goto class word is a goto |
| intc_o | output | 4 | Interrupt-control action code |
| int_en_o | output | 2 | Enable bits for the set-enables action |
| push_o | output | 1 | Stack transfer is a push |
| stk_cnt_o | output | 3 | Stack transfer register count |

## Verification
The assertions assume that `instr_i` is stable across each rising edge. They also assume it carries a defined value whenever `rst_n` is high, because the checker relates each output to the word sampled one edge earlier. The bench changes `instr_i` only on falling edges and never leaves it undefined. After reset, a settle flag in the checker suppresses the lookback properties for the first edge, so that no reset-time word is related to the outputs. The stimulus consists of one directed encoding per decode path, a mid-run reset, and a sweep over every 16-bit word. Together these cover both legal and illegal encodings.

// File: rtl/idec_pkg.sv
// Shared constants and types for the instruction word decoder.
// Assumes a 16-bit word with fixed field positions; all widths derive from here.
package idec_pkg;

    localparam int WORD_W  = 16;
    localparam int OPC_W   = 4;
    localparam int REG_W   = 3;
    localparam int FLD_W   = 3;
    localparam int IMM_W   = 2 * FLD_W;
    localparam int LEN_W   = 5;

    localparam logic [OPC_W-1:0] OP_SPECIAL = 4'hF;
    localparam logic [OPC_W-1:0] OP_LOAD    = 4'h9;
    localparam logic [OPC_W-1:0] OP_STORE   = 4'hD;
    localparam logic [REG_W-1:0] PC_REG     = 3'd7;
    localparam logic [FLD_W-1:0] SEC_STACK  = 3'd2;
    localparam logic [LEN_W-1:0] MAC_FULL   = 5'd16;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_ALU   = 3'd1,
        CLS_JUMP  = 3'd2,
        CLS_MUL   = 3'd3,
        CLS_MAC   = 3'd4,
        CLS_XFER  = 3'd5,
        CLS_INTC  = 3'd6,
        CLS_STACK = 3'd7
    } iclass_e;

    typedef enum logic [3:0] {
        AM_NONE  = 4'd0,
        AM_BPREL = 4'd1,
        AM_IMM6  = 4'd2,
        AM_IND   = 4'd3,
        AM_REG   = 4'd4,
        AM_IMM16 = 4'd5,
        AM_LDA16 = 4'd6,
        AM_STA16 = 4'd7,
        AM_ASR   = 4'd8,
        AM_LSL   = 4'd9,
        AM_LSR   = 4'd10,
        AM_ROL   = 4'd11,
        AM_ROR   = 4'd12,
        AM_ABS6  = 4'd13
    } amode_e;

    typedef enum logic [3:0] {
        IC_NONE     = 4'd0,
        IC_SETEN    = 4'd1,
        IC_CMOV_ON  = 4'd2,
        IC_CMOV_OFF = 4'd3,
        IC_NRM_OFF  = 4'd4,
        IC_NRM_ON   = 4'd5,
        IC_FST_OFF  = 4'd6,
        IC_FST_ON   = 4'd7,
        IC_BREAK    = 4'd8
    } intc_e;

    // Class-specific decode results; the raw register fields travel separately.
    typedef struct packed {
        iclass_e          cls;
        logic             illegal;
        logic             two_word;
        logic [OPC_W-1:0] alu_op;
        amode_e           amode;
        logic [2:0]       shamt;
        logic             ind_ds;
        logic [1:0]       ind_upd;
        logic [OPC_W-1:0] jcond;
        logic             jback;
        logic             mul_signed;
        logic [LEN_W-1:0] mac_len;
        logic             is_goto;
        intc_e            intc;
        logic [1:0]       int_en;
        logic             push;
        logic [FLD_W-1:0] stk_cnt;
    } dec_t;

    // Registers that can never feed the multiplier.
    function automatic logic reg_bad_mul(input logic [REG_W-1:0] r);
        return (r == 3'd0) || (r == 3'd6) || (r == PC_REG);
    endfunction

    // Registers reserved for the accumulation result in MAC.
    function automatic logic reg_bad_mac(input logic [REG_W-1:0] r);
        return (r == 3'd3) || (r == 3'd4);
    endfunction

    // Primary opcodes that name an ALU operation.
    function automatic logic alu_code_ok(input logic [OPC_W-1:0] op);
        return !((op == 4'h5) || (op == 4'h7) || (op == 4'hE) || (op == OP_SPECIAL));
    endfunction

endpackage

// File: rtl/idec_gen.sv
// Decodes words outside the special group: jumps, ALU forms, stack transfers.
// Assumes the caller selects this result only when the primary opcode is not 0xF.
module idec_gen
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    input  logic [REG_W-1:0] ra_i,
    input  logic [FLD_W-1:0] sec_i,
    input  logic [FLD_W-1:0] par_i,
    output dec_t             dec_o
);

    logic ill;
    logic [2:0] shamt;

    assign shamt = {1'b0, par_i[1:0]} + 3'd1;

    // Jump takes precedence, then unused opcodes, then stack, then ALU modes.
    always_comb begin
        dec_o = '0;
        ill   = 1'b0;
        if (ra_i == PC_REG) begin
            dec_o.cls   = CLS_JUMP;
            dec_o.jcond = op_i;
            dec_o.jback = sec_i[0];
            ill         = |sec_i[2:1];
        end else if (!alu_code_ok(op_i)) begin
            ill = 1'b1;
        end else if (sec_i == SEC_STACK) begin
            if (op_i == OP_LOAD || op_i == OP_STORE) begin
                dec_o.cls     = CLS_STACK;
                dec_o.push    = (op_i == OP_STORE);
                dec_o.stk_cnt = par_i;
            end else begin
                ill = 1'b1;
            end
        end else begin
            dec_o.cls    = CLS_ALU;
            dec_o.alu_op = op_i;
            case (sec_i)
                3'd0: dec_o.amode = AM_BPREL;
                3'd1: dec_o.amode = AM_IMM6;
                3'd3: begin
                    dec_o.amode   = AM_IND;
                    dec_o.ind_ds  = par_i[2];
                    dec_o.ind_upd = par_i[1:0];
                end
                3'd4: begin
                    case (par_i)
                        3'd0: dec_o.amode = AM_REG;
                        3'd1: dec_o.amode = AM_IMM16;
                        3'd2: dec_o.amode = AM_LDA16;
                        3'd3: dec_o.amode = AM_STA16;
                        default: begin
                            dec_o.amode = AM_ASR;
                            dec_o.shamt = shamt;
                        end
                    endcase
                    dec_o.two_word = (par_i != 3'd0) && !par_i[2];
                end
                3'd5: begin
                    dec_o.amode = par_i[2] ? AM_LSR : AM_LSL;
                    dec_o.shamt = shamt;
                end
                3'd6: begin
                    dec_o.amode = par_i[2] ? AM_ROR : AM_ROL;
                    dec_o.shamt = shamt;
                end
                default: dec_o.amode = AM_ABS6;
            endcase
        end
        if (ill) begin
            dec_o         = '0;
            dec_o.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/idec_spec.sv
// Decodes the special group: multiply, MAC, call/goto, interrupt control.
// Assumes the caller selects this result only when the primary opcode is 0xF.
module idec_spec
    import idec_pkg::*;
(
    input  logic [REG_W-1:0] ra_i,
    input  logic [FLD_W-1:0] sec_i,
    input  logic [FLD_W-1:0] par_i,
    input  logic [REG_W-1:0] rb_i,
    output dec_t             dec_o
);

    logic             ill;
    logic             bad_mul;
    logic             bad_mac;
    logic [IMM_W-1:0] imm;
    logic [LEN_W-1:0] len;

    assign imm     = {par_i, rb_i};
    assign bad_mul = reg_bad_mul(ra_i) || reg_bad_mul(rb_i);
    assign bad_mac = bad_mul || reg_bad_mac(ra_i) || reg_bad_mac(rb_i);
    assign len     = {1'b0, sec_i[0], par_i};

    // Secondary opcode picks the sub-class; operand limits make a word illegal.
    always_comb begin
        dec_o = '0;
        ill   = 1'b0;
        case (sec_i)
            3'd0, 3'd4: begin
                if (par_i == 3'd1 && !bad_mul) begin
                    dec_o.cls        = CLS_MUL;
                    dec_o.mul_signed = sec_i[2];
                end else begin
                    ill = 1'b1;
                end
            end
            3'd1: begin
                dec_o.cls      = CLS_XFER;
                dec_o.two_word = 1'b1;
            end
            3'd5: begin
                dec_o.cls = CLS_INTC;
                case (imm)
                    6'h00, 6'h01, 6'h02, 6'h03: begin
                        dec_o.intc   = IC_SETEN;
                        dec_o.int_en = imm[1:0];
                    end
                    6'h04:   dec_o.intc = IC_CMOV_ON;
                    6'h05:   dec_o.intc = IC_CMOV_OFF;
                    6'h08:   dec_o.intc = IC_NRM_OFF;
                    6'h09:   dec_o.intc = IC_NRM_ON;
                    6'h0C:   dec_o.intc = IC_FST_OFF;
                    6'h0E:   dec_o.intc = IC_FST_ON;
                    6'h20:   dec_o.intc = IC_BREAK;
                    default: ill = 1'b1;
                endcase
            end
            default: begin
                if (sec_i == 3'd2 && ra_i == PC_REG) begin
                    dec_o.cls      = CLS_XFER;
                    dec_o.two_word = 1'b1;
                    dec_o.is_goto  = 1'b1;
                end else if (!bad_mac) begin
                    dec_o.cls        = CLS_MAC;
                    dec_o.mul_signed = sec_i[2];
                    dec_o.mac_len    = (len == '0) ? MAC_FULL : len;
                end else begin
                    ill = 1'b1;
                end
            end
        endcase
        if (ill) begin
            dec_o         = '0;
            dec_o.illegal = 1'b1;
        end
    end

endmodule

// File: rtl/idec_word.sv
// Top of the instruction word decoder: splits the word, runs both group
// decoders in parallel, selects by primary opcode and registers the result.
// Assumes instr_i is stable at each rising edge; reset is synchronous, active low.
module idec_word
    import idec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_i,
    output logic [2:0]        cls_o,
    output logic              illegal_o,
    output logic              two_word_o,
    output logic [OPC_W-1:0]  alu_op_o,
    output logic [3:0]        amode_o,
    output logic [2:0]        shamt_o,
    output logic              ind_ds_o,
    output logic [1:0]        ind_upd_o,
    output logic [REG_W-1:0]  ra_o,
    output logic [REG_W-1:0]  rb_o,
    output logic [IMM_W-1:0]  imm6_o,
    output logic [OPC_W-1:0]  jcond_o,
    output logic              jback_o,
    output logic              mul_signed_o,
    output logic [LEN_W-1:0]  mac_len_o,
    output logic              goto_o,
    output logic [3:0]        intc_o,
    output logic [1:0]        int_en_o,
    output logic              push_o,
    output logic [FLD_W-1:0]  stk_cnt_o
);

    localparam int RA_LSB  = WORD_W - OPC_W - REG_W;
    localparam int SEC_LSB = RA_LSB - FLD_W;
    localparam int PAR_LSB = SEC_LSB - FLD_W;

    logic [OPC_W-1:0] op;
    logic [REG_W-1:0] ra;
    logic [FLD_W-1:0] sec;
    logic [FLD_W-1:0] par;
    logic [REG_W-1:0] rb;
    dec_t             dec_gen;
    dec_t             dec_spc;
    dec_t             dec_nxt;
    dec_t             dec_q;
    logic [REG_W-1:0] ra_q;
    logic [REG_W-1:0] rb_q;
    logic [IMM_W-1:0] imm_q;

    assign op  = instr_i[WORD_W-1 -: OPC_W];
    assign ra  = instr_i[RA_LSB +: REG_W];
    assign sec = instr_i[SEC_LSB +: FLD_W];
    assign par = instr_i[PAR_LSB +: FLD_W];
    assign rb  = instr_i[REG_W-1:0];

    idec_gen u_gen (
        .op_i  (op),
        .ra_i  (ra),
        .sec_i (sec),
        .par_i (par),
        .dec_o (dec_gen)
    );

    idec_spec u_spec (
        .ra_i  (ra),
        .sec_i (sec),
        .par_i (par),
        .rb_i  (rb),
        .dec_o (dec_spc)
    );

    // The special opcode overrides every other interpretation of the word.
    assign dec_nxt = (op == OP_SPECIAL) ? dec_spc : dec_gen;

    // Output stage: capture the selected decode and the raw fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '0;
            ra_q  <= '0;
            rb_q  <= '0;
            imm_q <= '0;
        end else begin
            dec_q <= dec_nxt;
            ra_q  <= ra;
            rb_q  <= rb;
            imm_q <= {par, rb};
        end
    end

    assign cls_o        = dec_q.cls;
    assign illegal_o    = dec_q.illegal;
    assign two_word_o   = dec_q.two_word;
    assign alu_op_o     = dec_q.alu_op;
    assign amode_o      = dec_q.amode;
    assign shamt_o      = dec_q.shamt;
    assign ind_ds_o     = dec_q.ind_ds;
    assign ind_upd_o    = dec_q.ind_upd;
    assign ra_o         = ra_q;
    assign rb_o         = rb_q;
    assign imm6_o       = imm_q;
    assign jcond_o      = dec_q.jcond;
    assign jback_o      = dec_q.jback;
    assign mul_signed_o = dec_q.mul_signed;
    assign mac_len_o    = dec_q.mac_len;
    assign goto_o       = dec_q.is_goto;
    assign intc_o       = dec_q.intc;
    assign int_en_o     = dec_q.int_en;
    assign push_o       = dec_q.push;
    assign stk_cnt_o    = dec_q.stk_cnt;

endmodule

// File: rtl/idec_word_chk.sv
// Property checker for idec_word, attached by bind below.
// Assumes instr_i is defined while rst_n is high; lookback waits one settled edge.
module idec_word_chk
    import idec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] instr_i,
    input logic [2:0]        cls_o,
    input logic              illegal_o,
    input logic              two_word_o,
    input logic [3:0]        amode_o,
    input logic [OPC_W-1:0]  jcond_o,
    input logic [REG_W-1:0]  ra_o,
    input logic [REG_W-1:0]  rb_o,
    input logic [LEN_W-1:0]  mac_len_o,
    input logic [3:0]        intc_o,
    input logic              push_o
);

    logic settled;

    // Marks that the previous edge was taken out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) settled <= 1'b0;
        else        settled <= 1'b1;
    end

    p_special_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $past(instr_i[15:12]) == OP_SPECIAL)
        |-> !(cls_o == CLS_ALU || cls_o == CLS_JUMP || cls_o == CLS_STACK));

    p_jump_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $past(instr_i[11:9]) == PC_REG && $past(instr_i[15:12]) != OP_SPECIAL
         && $past(instr_i[8:7]) == 2'b00)
        |-> (cls_o == CLS_JUMP && jcond_o == $past(instr_i[15:12])));

    p_two_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        two_word_o |-> (cls_o == CLS_XFER ||
                        (cls_o == CLS_ALU && amode_o >= AM_IMM16 && amode_o <= AM_STA16)));

    p_mul_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_o == CLS_MUL || cls_o == CLS_MAC)
        |-> !(reg_bad_mul(ra_o) || reg_bad_mul(rb_o)));

    p_mac_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cls_o == CLS_MAC)
        |-> (mac_len_o != '0 && mac_len_o <= MAC_FULL && !reg_bad_mac(ra_o) && !reg_bad_mac(rb_o)));

    p_intc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (intc_o != IC_NONE) |-> (cls_o == CLS_INTC));

    p_illegal_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cls_o == CLS_NONE && !two_word_o && amode_o == AM_NONE
                       && intc_o == IC_NONE && !push_o && mac_len_o == '0));

endmodule

bind idec_word idec_word_chk u_chk (.*);

// File: tb/tb_idec_word.sv
// Self-checking bench: a behavioural model of the encoding rules predicts
// every output, and the outputs are compared on every clock.
module tb_idec_word;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] instr = 16'h0000;

    logic [2:0] cls_o;
    logic       illegal_o, two_word_o, ind_ds_o, jback_o, mul_signed_o, goto_o, push_o;
    logic [3:0] alu_op_o, amode_o, jcond_o, intc_o;
    logic [2:0] shamt_o, ra_o, rb_o, stk_cnt_o;
    logic [1:0] ind_upd_o, int_en_o;
    logic [5:0] imm6_o;
    logic [4:0] mac_len_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [52:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    idec_word dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr),
        .cls_o(cls_o), .illegal_o(illegal_o), .two_word_o(two_word_o),
        .alu_op_o(alu_op_o), .amode_o(amode_o), .shamt_o(shamt_o),
        .ind_ds_o(ind_ds_o), .ind_upd_o(ind_upd_o), .ra_o(ra_o), .rb_o(rb_o),
        .imm6_o(imm6_o), .jcond_o(jcond_o), .jback_o(jback_o),
        .mul_signed_o(mul_signed_o), .mac_len_o(mac_len_o), .goto_o(goto_o),
        .intc_o(intc_o), .int_en_o(int_en_o), .push_o(push_o), .stk_cnt_o(stk_cnt_o)
    );

    function automatic logic [52:0] observed();
        return {cls_o, illegal_o, two_word_o, alu_op_o, amode_o, shamt_o, ind_ds_o,
                ind_upd_o, ra_o, rb_o, imm6_o, jcond_o, jback_o, mul_signed_o,
                mac_len_o, goto_o, intc_o, int_en_o, push_o, stk_cnt_o};
    endfunction

    // Behavioural prediction written straight from the requirements.
    function automatic logic [52:0] model(input logic [15:0] w);
        int op = int'(w[15:12]);
        int a  = int'(w[11:9]);
        int s  = int'(w[8:6]);
        int p  = int'(w[5:3]);
        int b  = int'(w[2:0]);
        int im = int'(w[5:0]);
        int cls = 0, ill = 0, tw = 0, aop = 0, am = 0, sh = 0, ds = 0, upd = 0;
        int jc = 0, jb = 0, ms = 0, ml = 0, gt = 0, ic = 0, ien = 0, pu = 0, cnt = 0;
        bit badm = (a == 0 || a == 6 || a == 7 || b == 0 || b == 6 || b == 7);
        bit badc = badm || a == 3 || a == 4 || b == 3 || b == 4;
        if (op == 15) begin
            if (s == 0 || s == 4) begin
                if (p == 1 && !badm) begin cls = 3; ms = (s == 4); end else ill = 1;
            end else if (s == 1) begin
                cls = 5; tw = 1;
            end else if (s == 5) begin
                cls = 6;
                if (im <= 3) begin ic = 1; ien = im; end
                else if (im == 4)  ic = 2;
                else if (im == 5)  ic = 3;
                else if (im == 8)  ic = 4;
                else if (im == 9)  ic = 5;
                else if (im == 12) ic = 6;
                else if (im == 14) ic = 7;
                else if (im == 32) ic = 8;
                else ill = 1;
            end else if (s == 2 && a == 7) begin
                cls = 5; tw = 1; gt = 1;
            end else if (!badc) begin
                cls = 4; ms = (s >= 6); ml = (s % 2) * 8 + p;
                if (ml == 0) ml = 16;
            end else ill = 1;
        end else if (a == 7) begin
            if (s > 1) ill = 1; else begin cls = 2; jc = op; jb = s; end
        end else if (op == 5 || op == 7 || op == 14) begin
            ill = 1;
        end else if (s == 2) begin
            if (op == 9 || op == 13) begin cls = 7; pu = (op == 13); cnt = p; end
            else ill = 1;
        end else begin
            cls = 1; aop = op;
            case (s)
                0: am = 1;
                1: am = 2;
                3: begin am = 3; ds = p / 4; upd = p % 4; end
                4: begin
                    if (p == 0) am = 4;
                    else if (p < 4) begin am = 4 + p; tw = 1; end
                    else begin am = 8; sh = p % 4 + 1; end
                end
                5: begin am = (p < 4) ? 9 : 10;  sh = p % 4 + 1; end
                6: begin am = (p < 4) ? 11 : 12; sh = p % 4 + 1; end
                default: am = 13;
            endcase
        end
        if (ill == 1) begin
            cls = 0; tw = 0; aop = 0; am = 0; sh = 0; ds = 0; upd = 0; jc = 0; jb = 0;
            ms = 0; ml = 0; gt = 0; ic = 0; ien = 0; pu = 0; cnt = 0;
        end
        return {3'(cls), 1'(ill), 1'(tw), 4'(aop), 4'(am), 3'(sh), 1'(ds), 2'(upd),
                3'(a), 3'(b), 6'(im), 4'(jc), 1'(jb), 1'(ms), 5'(ml), 1'(gt),
                4'(ic), 2'(ien), 1'(pu), 3'(cnt)};
    endfunction

    task automatic check(input logic [52:0] expv, input string tag);
        logic [52:0] got = observed();
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    // One clock: compare the word applied last cycle, then apply the next one.
    task automatic apply(input logic [15:0] w, input string tag);
        @(negedge clk);
        if (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
        instr = w;
        exp_q.push_back(model(w));
        tag_q.push_back(tag);
    endtask

    task automatic flush();
        @(negedge clk);
        while (exp_q.size() > 0) check(exp_q.pop_front(), tag_q.pop_front());
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(1_600_000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        instr = 16'hFFFF;
        repeat (3) @(negedge clk);
        check('0, "R1 reset clears outputs");
        rst_n = 1'b1;

        apply(16'h0205, "R4 R5 add base-relative");
        apply(16'h267F, "R5 sub imm6");
        apply(16'h94F4, "R6 load indirect ds post-increment");
        apply(16'h030A, "R7 add imm16 two words");
        apply(16'hD318, "R7 store to addr16");
        apply(16'hB33A, "R6 asr by 4");
        apply(16'h0361, "R6 lsr by 1");
        apply(16'h0389, "R5 rol by 2");
        apply(16'hC5D5, "R5 absolute addr6");
        apply(16'h5200, "R4 unused opcode 5 illegal");
        apply(16'h5E03, "R3 jump equal forward");
        apply(16'hEE41, "R3 jump always backward");
        apply(16'h0E80, "R3 jump bad direction illegal");
        apply(16'h9A90, "R8 pop");
        apply(16'hD498, "R8 push");
        apply(16'h0480, "R8 stack slot on add illegal");
        apply(16'hF20A, "R9 mul unsigned-signed");
        apply(16'hF30A, "R9 mul signed-signed");
        apply(16'hF20E, "R9 mul with reg 6 illegal");
        apply(16'hF212, "R9 mul bad parameter illegal");
        apply(16'hF282, "R10 mac length 16");
        apply(16'hF3DA, "R10 mac signed length 11");
        apply(16'hF283, "R10 mac with reg 3 illegal");
        apply(16'hF052, "R11 call");
        apply(16'hFE85, "R11 goto");
        apply(16'hF142, "R12 set fast enable only");
        apply(16'hF144, "R12 coefficient move on");
        apply(16'hF148, "R12 normal interrupt off");
        apply(16'hF149, "R12 normal interrupt on");
        apply(16'hF14C, "R12 fast interrupt off");
        apply(16'hF14E, "R12 fast interrupt on");
        apply(16'hF160, "R12 break");
        apply(16'hF14D, "R13 unknown interrupt code illegal");
        apply(16'hF2A5, "R2 special group mac");
        flush();

        // Mid-run reset: the next edge must clear the outputs again.
        @(negedge clk);
        rst_n = 1'b0;
        instr = 16'h2A5B;
        @(negedge clk);
        check('0, "R1 mid-run reset clears outputs");
        rst_n = 1'b1;

        for (int i = 0; i < 65536; i++) begin
            apply(16'(i), "R13 full word sweep");
        end
        flush();

        done = 1;
        report();
        $finish;
    end

endmodule